// File: doc/BRIEF.md
# Interrupt and Square-Wave Output Controller

This block owns one shared output pin that either signals interrupts from three sources (watchdog, alarm, power-fail) or carries a programmable square wave. Each source raises a sticky flag whenever its event strobe fires. If that source is also enabled, the event asserts the pin. The pin then stays asserted either for a fixed pulse or until the host reads the flags.

An 8-bit control word selects the behaviour:

- which sources may drive the pin;
- whether the square wave takes over the pin;
- push-pull active-high or open-drain active-low drive;
- pulse or level hold;
- one of four wave frequencies.

The whole block runs on the 32.768 kHz oscillator clock. Every duration below is counted in oscillator cycles.

Control word layout:

| Bits | Field |
|------|-------|
| [0] | watchdog enable |
| [1] | alarm enable |
| [2] | power-fail enable |
| [3] | square-wave enable |
| [4] | high drive (1 = push-pull active-high, 0 = open-drain active-low) |
| [5] | pulse mode (1 = pulse, 0 = level) |
| [7:6] | frequency select |

Top module: `irq_sqw_ctrl`

## Requirements
- R1: After reset the control word is 0x00, all flags are 0, and the pin is released (`pin_oe`=0, `pin_o`=0).
- R2: An event strobe sets its flag one cycle later, whatever its enable bit or the square-wave enable says. Flags are ordered watchdog, alarm, power-fail.
- R3: An event from a source whose enable bit (ctl[0]/[1]/[2]) is 0 never asserts the pin.
- R4: In high drive (ctl[4]=1), an enabled event drives `pin_o`=1 with `pin_oe`=1 one cycle after the strobe. When inactive, the pin drives `pin_o`=0 with `pin_oe`=1.
- R5: In open-drain mode (ctl[4]=0), `pin_o` is always 0. `pin_oe` is 1 while the pin is active and 0 while it is inactive.
- R6: In level mode (ctl[5]=0), the assertion holds until a flags read. That read clears all flags and releases the pin at the same clock edge.
- R7: In pulse mode (ctl[5]=1), the pin stays active for exactly PULSE_CYCLES (default 6554) cycles. A flags read does not shorten the pulse.
- R8: An enabled event arriving during an active pulse restarts the full pulse length.
- R9: When a flags read and an event coincide, the flag of that event remains set and the other flags are cleared.
- R10: While ctl[3]=1, the pin carries the square wave and enabled events only set flags. Clearing ctl[3] afterwards leaves the pin inactive.
- R11: Frequency select ctl[7:6] sets the square-wave half period: 00 gives 16384 cycles (1 Hz), 01 gives 32 cycles (512 Hz), 10 gives 4 cycles (4096 Hz), and 11 makes the pin follow the oscillator clock itself (32768 Hz).
- R12: A square wave in open-drain mode keeps `pin_o`=0 and drives `pin_oe` as the inverse of the wave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_wdog | input | 1 | Watchdog event strobe |
| evt_alarm | input | 1 | Alarm event strobe |
| evt_pfail | input | 1 | Power-fail event strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| flags_rd | input | 1 | Flags read strobe (clears flags) |
| pin_o | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |
| flag_wdog | output | 1 | Sticky watchdog flag |
| flag_alarm | output | 1 | Sticky alarm flag |
| flag_pfail | output | 1 | Sticky power-fail flag |

## Verification
A corrupted flag register shows on the flag outputs at the very next cycle, because each flag is a direct register output. A hold state that is stuck, or that is lost early, shows on the pin either immediately or only at the end of the pulse window, up to 6554 cycles later. Pulses are therefore counted in full, sample by sample, rather than spot-checked. A wrong divider tap shows within one half period, which can take up to 16384 cycles at the slowest setting.

// File: rtl/irq_sqw_pkg.sv
package irq_sqw_pkg;

  localparam int NSRC = 3;

  // Control word: MSB first in the packed struct
  typedef struct packed {
    logic [1:0]      fsel;   // [7:6] square-wave frequency select
    logic            pulse;  // [5]   1 = pulse hold, 0 = level hold
    logic            hi;     // [4]   1 = push-pull active-high
    logic            sqwe;   // [3]   square wave owns the pin
    logic [NSRC-1:0] en;     // [2:0] pfail, alarm, wdog enables
  } ctl_t;

  // Divider bit whose toggling yields the selected frequency.
  // Bit k of a free-running counter has a half period of 2^k cycles.
  function automatic int sqw_tap(input logic [1:0] sel, input int div_w);
    case (sel)
      2'd0:    return div_w - 1;   // 1 Hz
      2'd1:    return div_w - 10;  // 512 Hz
      2'd2:    return div_w - 13;  // 4096 Hz
      default: return 0;           // clock passes through, tap unused
    endcase
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            rd_i,
  output logic [NSRC-1:0] flag_o
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_kept;

  // A read wipes history; a coincident event survives the read
  assign flag_kept = rd_i ? '0 : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_kept | evt_i;
  end

  assign flag_o = flag_q;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_chk
      AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[s] |=> flag_o[s]); // R2
    end
  endgenerate

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i == '0) |=> (flag_o == '0)); // R6

endmodule

// File: rtl/irq_hold.sv
module irq_hold #(
  parameter int PULSE_CYCLES = 6554
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,   // enabled event this cycle
  input  logic rd_i,     // flags read strobe
  input  logic pulse_i,  // 1 = timed pulse, 0 = level
  input  logic sqwe_i,   // square wave owns the pin
  output logic act_o
);

  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_done;
  logic             level_release;

  assign pulse_done    = act_q && pulse_i && (cnt_q == '0);
  assign level_release = act_q && !pulse_i && rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (sqwe_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (trig_i) begin
      act_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (pulse_done || level_release) begin
      act_q <= 1'b0;
    end else if (act_q && pulse_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign act_o = act_q;

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !trig_i) |=> !act_q); // R3

  AST_SQW_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    sqwe_i |=> !act_q); // R10

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !pulse_i && !rd_i && !sqwe_i) |=> act_q); // R6

  AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !sqwe_i) |=> (act_q && cnt_q == LOAD)); // R8

  AST_PULSE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && pulse_i && cnt_q == '0 && !trig_i && !sqwe_i) |=> !act_q); // R7

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output logic       wave_o
);
  import irq_sqw_pkg::*;

  localparam int IDX_W = $clog2(DIV_W);

  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] tap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tap_idx = IDX_W'(sqw_tap(sel_i, DIV_W));
  assign wave_o  = (sel_i == 2'd3) ? clk : div_q[tap_idx];

  AST_DIV_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (div_q != $past(div_q))); // R11

endmodule

// File: rtl/irq_sqw_ctrl.sv
module irq_sqw_ctrl #(
  parameter int PULSE_CYCLES = 6554,
  parameter int DIV_W        = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_wdog,
  input  logic       evt_alarm,
  input  logic       evt_pfail,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       flags_rd,
  output logic       pin_o,
  output logic       pin_oe,
  output logic       flag_wdog,
  output logic       flag_alarm,
  output logic       flag_pfail
);
  import irq_sqw_pkg::*;

  ctl_t            ctl_q;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] flag_vec;
  logic            trig;
  logic            act;
  logic            wave;
  logic            level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  assign evt_vec = {evt_pfail, evt_alarm, evt_wdog};
  assign trig    = |(evt_vec & ctl_q.en);

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_vec),
    .rd_i   (flags_rd),
    .flag_o (flag_vec)
  );

  irq_hold #(.PULSE_CYCLES(PULSE_CYCLES)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig),
    .rd_i    (flags_rd),
    .pulse_i (ctl_q.pulse),
    .sqwe_i  (ctl_q.sqwe),
    .act_o   (act)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (ctl_q.fsel),
    .wave_o (wave)
  );

  // Logical line level, then mapped onto the chosen drive style
  assign level  = ctl_q.sqwe ? wave : act;
  assign pin_o  = ctl_q.hi & level;
  assign pin_oe = ctl_q.hi | (ctl_q.sqwe ? ~wave : act);

  assign flag_wdog  = flag_vec[0];
  assign flag_alarm = flag_vec[1];
  assign flag_pfail = flag_vec[2];

  AST_ASSERT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(trig)); // R4

endmodule

// File: tb/test_irq_sqw_ctrl.sv
module test_irq_sqw_ctrl;
  localparam int P = 6554;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_wdog = 0, evt_alarm = 0, evt_pfail = 0;
  logic ctl_we = 0;
  logic [7:0] ctl_wdata = 8'h00;
  logic flags_rd = 0;
  logic pin_o, pin_oe, flag_wdog, flag_alarm, flag_pfail;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_sqw_ctrl i_irq_sqw_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evt_wdog(evt_wdog), .evt_alarm(evt_alarm), .evt_pfail(evt_pfail),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .flags_rd(flags_rd),
    .pin_o(pin_o), .pin_oe(pin_oe),
    .flag_wdog(flag_wdog), .flag_alarm(flag_alarm), .flag_pfail(flag_pfail)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic rd_flags();
    flags_rd = 1'b1;
    tick();
    flags_rd = 1'b0;
  endtask

  // Half period of pin_o (which=0) or pin_oe (which=1), in cycles
  task automatic half_period(input int which, output int n);
    logic v0;
    int guard;
    v0 = which ? pin_oe : pin_o;
    guard = 0;
    while (((which ? pin_oe : pin_o) == v0) && guard < 40000) begin
      tick();
      guard++;
    end
    v0 = which ? pin_oe : pin_o;
    n = 0;
    while (((which ? pin_oe : pin_o) == v0) && n < 40000) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_o", pin_o, 0);
    chk("R1 flags", {flag_pfail, flag_alarm, flag_wdog}, 0);
  endtask

  task automatic t_disabled();
    wr_ctl(8'h10);                      // high drive, no enables
    evt_wdog = 1'b1;
    tick();
    evt_wdog = 1'b0;
    chk("R2 wdog flag without enable", flag_wdog, 1);
    chk("R3 disabled source pin", pin_o, 0);
    chk("R4 inactive high drive oe", pin_oe, 1);
    for (int i = 0; i < 5; i++) tick();
    chk("R3 disabled source later", pin_o, 0);
    rd_flags();
    chk("R6 flags cleared", flag_wdog, 0);
  endtask

  task automatic t_level_hi();
    wr_ctl(8'h11);                      // high drive, level, wdog enabled
    evt_wdog = 1'b1;
    tick();
    evt_wdog = 1'b0;
    chk("R4 assert pin_o", pin_o, 1);
    chk("R4 assert pin_oe", pin_oe, 1);
    for (int i = 0; i < 20; i++) tick();
    chk("R6 level held", pin_o, 1);
    rd_flags();
    chk("R6 released on read", pin_o, 0);
    chk("R6 flag cleared on read", flag_wdog, 0);
  endtask

  task automatic t_open_drain();
    wr_ctl(8'h02);                      // open drain, level, alarm enabled
    chk("R5 idle oe", pin_oe, 0);
    evt_alarm = 1'b1;
    tick();
    evt_alarm = 1'b0;
    chk("R5 active oe", pin_oe, 1);
    chk("R5 active data", pin_o, 0);
    chk("R2 alarm flag", flag_alarm, 1);
    rd_flags();
    chk("R5 released oe", pin_oe, 0);
  endtask

  task automatic t_read_race();
    wr_ctl(8'h10);
    evt_wdog = 1'b1;
    evt_pfail = 1'b1;
    tick();
    evt_wdog = 1'b0;
    evt_pfail = 1'b0;
    flags_rd = 1'b1;
    evt_alarm = 1'b1;
    tick();
    flags_rd = 1'b0;
    evt_alarm = 1'b0;
    chk("R9 flags after race", {flag_pfail, flag_alarm, flag_wdog}, 3'b010);
    rd_flags();
  endtask

  task automatic t_pulse();
    int hi;
    wr_ctl(8'h34);                      // pulse, high drive, pfail enabled
    evt_pfail = 1'b1;
    tick();
    evt_pfail = 1'b0;
    hi = 0;
    for (int i = 0; i < P + 20; i++) begin
      if (pin_o) hi++;
      flags_rd = (i == 100);
      tick();
    end
    flags_rd = 1'b0;
    chk("R7 pulse length", hi, P);
    chk("R7 flag cleared by read", flag_pfail, 0);
  endtask

  task automatic t_retrigger();
    int hi;
    wr_ctl(8'h34);
    evt_pfail = 1'b1;
    tick();
    evt_pfail = 1'b0;
    for (int i = 0; i < 1000; i++) tick();
    evt_pfail = 1'b1;
    tick();
    evt_pfail = 1'b0;
    hi = 0;
    for (int i = 0; i < P + 20; i++) begin
      if (pin_o) hi++;
      tick();
    end
    chk("R8 restarted pulse length", hi, P);
    rd_flags();
  endtask

  task automatic t_square();
    int n;
    wr_ctl(8'h9F);                      // 4096 Hz, sqw, high, level, all enabled
    evt_wdog = 1'b1;
    tick();
    evt_wdog = 1'b0;
    chk("R10 flag set in sqw mode", flag_wdog, 1);
    half_period(0, n);
    chk("R11 4096 Hz half period", n, 4);
    wr_ctl(8'h17);                      // leave sqw mode
    chk("R10 no stale assertion", pin_o, 0);
    rd_flags();
    wr_ctl(8'h58);                      // 512 Hz
    half_period(0, n);
    chk("R11 512 Hz half period", n, 32);
    wr_ctl(8'h18);                      // 1 Hz
    half_period(0, n);
    chk("R11 1 Hz half period", n, 16384);
    wr_ctl(8'hD8);                      // clock pass-through
    for (int i = 0; i < 3; i++) begin
      chk("R11 pass-through high phase", pin_o, 1);
      #5;
      chk("R11 pass-through low phase", pin_o, 0);
      tick();
    end
  endtask

  task automatic t_square_od();
    int n;
    int bad;
    wr_ctl(8'h88);                      // 4096 Hz, sqw, open drain
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (pin_o) bad++;
      tick();
    end
    chk("R12 open drain data low", bad, 0);
    half_period(1, n);
    chk("R12 open drain oe half period", n, 4);
  endtask

  initial begin
    #(10 * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    tick();
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_disabled();
    t_level_hi();
    t_open_drain();
    t_read_race();
    t_pulse();
    t_retrigger();
    t_square();
    t_square_od();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule